// File: doc/BRIEF.md
# 5B Code-Group Alignment Monitor

This block watches a receive bit stream that carries 5-bit line codes but has no known symbol boundary. While hunting, it keeps the ten most recent bits and compares them, bit by bit, against the start-of-stream delimiter pair. The pair is J (11000) followed at once by K (10001). When the pair matches, the block locks the boundary at that point. From then on it cuts every five accepted bits into one symbol, on that boundary only. It presents each symbol with a one-cycle strobe and flags each group that is not a legal code.

A stream that ends with T or R and is then followed by a run of Idle symbols releases the lock, and the block goes back to hunting. A drop of the signal-present input releases the lock at once.

The controller has three states. `ST_HUNT` searches for the delimiter. `ST_FRAME` delivers symbols inside a stream. `ST_TAIL` delivers symbols after an end code and counts consecutive Idles. The transitions are:
- hunt→frame when the delimiter matches.
- frame→tail on T or R.
- tail→frame on any other non-Idle symbol.
- tail→hunt on the `IDLE_RUN`-th consecutive Idle.
- any state→hunt on loss of signal.

Top module: `cg_align_monitor`

## Requirements
- R1: During and right after reset, `locked`, `sym_vld` and `code_err` are 0.
- R2: When the ten most recently accepted bits, oldest first, are 1100010001, `locked` is 1 from the cycle after the clock edge that accepted the last of them. Any number of leading bits is allowed.
- R3: While hunting, `sym_vld` and `code_err` stay 0, whatever bits arrive.
- R4: Once locked, every fifth accepted bit completes a symbol. `sym_vld` is then 1 for exactly one cycle, starting the cycle after that edge. `sym_out` carries the group, with the earliest received bit in bit 4.
- R5: A cycle with `bit_vld` = 0 accepts no bit and does not advance the group position.
- R6: `code_err` pulses together with `sym_vld` exactly for the ten illegal values: 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000 and 11001. The other 22 values are legal: the 16 data codes plus 11111, 11000, 10001, 01101, 00111 and 00100.
- R7: While locked, a J/K pattern that straddles the locked boundary does not move the boundary.
- R8: After T (01101) or R (00111), `IDLE_RUN` consecutive Idles (11111) clear `locked` in the cycle after the last Idle completes. That last Idle is still delivered with `sym_vld`.
- R9: A symbol other than Idle inside the Idle run restarts the run. A non-Idle, non-end symbol returns the block to `ST_FRAME`.
- R10: `sig_ok` = 0 at a clock edge clears `locked` from the next cycle and discards any partial group. A new delimiter is then needed.
- R11: `code_err` is never 1 without `sym_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_ok | input | 1 | Signal present; 0 drops alignment |
| bit_vld | input | 1 | `bit_in` carries a bit this cycle |
| bit_in | input | 1 | Serial NRZ bit |
| sym_out | output | 5 | Last aligned symbol, earliest bit in bit 4 |
| sym_vld | output | 1 | One-cycle strobe for a new symbol |
| locked | output | 1 | Symbol boundary is locked |
| code_err | output | 1 | One-cycle pulse for an illegal group |

## Verification
The hardest case to reach is a J/K pattern that arrives while the block is already locked and straddles the locked boundary. A design that keeps matching would silently realign. The stimulus locks first, then sends two filler bits ahead of J and K, so that the pattern sits across group edges. The bench then checks that the following groups are still cut on the old boundary.

The release path needs a precise order: an end code followed by exactly `IDLE_RUN` Idles, and in a second case an interruption inside the run. Both are driven against a behavioural model that is compared on every clock.

// File: rtl/cgam_pkg.sv
package cgam_pkg;
    localparam int SYM_W = 5;
    localparam int WIN_W = 2 * SYM_W;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FRAME = 2'd1,
        ST_TAIL  = 2'd2
    } cg_state_e;

    localparam logic [SYM_W-1:0] CG_J = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K = 5'b10001;
    localparam logic [SYM_W-1:0] CG_I = 5'b11111;
    localparam logic [SYM_W-1:0] CG_T = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R = 5'b00111;
    localparam logic [SYM_W-1:0] CG_H = 5'b00100;

    // Legal line codes: sixteen data values plus the control set.
    function automatic logic cg_is_legal(input logic [SYM_W-1:0] c);
        logic ok;
        case (c)
            5'b11110, 5'b01001, 5'b10100, 5'b10101,
            5'b01010, 5'b01011, 5'b01110, 5'b01111,
            5'b10010, 5'b10011, 5'b10110, 5'b10111,
            5'b11010, 5'b11011, 5'b11100, 5'b11101: ok = 1'b1;
            CG_I, CG_J, CG_K, CG_T, CG_R, CG_H:     ok = 1'b1;
            default:                                ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/cgam_window.sv
module cgam_window #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] win_next
);
    logic [W-1:0] win_q;

    assign win_next = {win_q[W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win_q <= '0;
        else if (clear)  win_q <= '0;
        else if (shift)  win_q <= win_next;
    end
endmodule

// File: rtl/cgam_slot.sv
module cgam_slot #(
    parameter int N = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    output logic done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    logic [CW-1:0] cnt_q;

    assign done = adv && (cnt_q == CW'(N - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (done)   cnt_q <= '0;
        else if (adv)    cnt_q <= cnt_q + 1'b1;
    end

    // R4: the group position never leaves its range
    a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(N - 1));
endmodule

// File: rtl/cgam_fsm.sv
module cgam_fsm
    import cgam_pkg::*;
#(
    parameter int IDLE_RUN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_ok,
    input  logic             bit_vld,
    input  logic             delim_hit,
    input  logic             grp_done,
    input  logic [SYM_W-1:0] grp,
    output logic             locked,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_vld,
    output logic             code_err
);
    localparam int IW = $clog2(IDLE_RUN + 1);

    cg_state_e      state_q, state_d;
    logic [IW-1:0]  idle_q, idle_d;
    logic           is_end, is_idle, emit;

    assign is_end  = (grp == CG_T) || (grp == CG_R);
    assign is_idle = (grp == CG_I);
    assign emit    = sig_ok && grp_done && (state_q != ST_HUNT);
    assign locked  = (state_q != ST_HUNT);

    always_comb begin
        state_d = state_q;
        idle_d  = idle_q;
        if (!sig_ok) begin
            state_d = ST_HUNT;
            idle_d  = '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    idle_d = '0;
                    if (bit_vld && delim_hit) state_d = ST_FRAME;
                end
                ST_FRAME: begin
                    if (grp_done && is_end) begin
                        state_d = ST_TAIL;
                        idle_d  = '0;
                    end
                end
                ST_TAIL: begin
                    if (grp_done) begin
                        if (is_idle) begin
                            if (idle_q == IW'(IDLE_RUN - 1)) begin
                                state_d = ST_HUNT;
                                idle_d  = '0;
                            end else begin
                                idle_d = idle_q + 1'b1;
                            end
                        end else if (is_end) begin
                            idle_d = '0;
                        end else begin
                            state_d = ST_FRAME;
                            idle_d  = '0;
                        end
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                    idle_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_out  <= '0;
            sym_vld  <= 1'b0;
            code_err <= 1'b0;
        end else begin
            sym_vld  <= emit;
            code_err <= emit && !cg_is_legal(grp);
            if (emit) sym_out <= grp;
        end
    end

    // R2: lock is only gained on an accepted bit completing the delimiter
    a_r2_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_vld && delim_hit && sig_ok));
    // R3: no symbol strobe after a cycle spent hunting
    a_r3_quiet_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && $past(!locked)) |-> !sym_vld);
    // R4: the strobe is a single-cycle pulse
    a_r4_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |=> !sym_vld);
    // R8: the idle run counter stays below its release value
    a_r8_idle_range: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q < IW'(IDLE_RUN));
    // R10: loss of signal releases the lock by the next cycle
    a_r10_los_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_ok |=> !locked);
    // R11: an error pulse always comes with a symbol strobe
    a_r11_err_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> sym_vld);
endmodule

// File: rtl/cg_align_monitor.sv
module cg_align_monitor
    import cgam_pkg::*;
#(
    parameter int IDLE_RUN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_ok,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_vld,
    output logic             locked,
    output logic             code_err
);
    logic [WIN_W-1:0] win_next;
    logic             delim_hit;
    logic             grp_done;

    cgam_window #(.W(WIN_W)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!sig_ok),
        .shift    (bit_vld),
        .bit_in   (bit_in),
        .win_next (win_next)
    );

    assign delim_hit = (win_next == {CG_J, CG_K});

    cgam_slot #(.N(SYM_W)) slot_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!sig_ok || !locked),
        .adv   (bit_vld && locked),
        .done  (grp_done)
    );

    cgam_fsm #(.IDLE_RUN(IDLE_RUN)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_ok    (sig_ok),
        .bit_vld   (bit_vld),
        .delim_hit (delim_hit),
        .grp_done  (grp_done),
        .grp       (win_next[SYM_W-1:0]),
        .locked    (locked),
        .sym_out   (sym_out),
        .sym_vld   (sym_vld),
        .code_err  (code_err)
    );
endmodule

// File: tb/cg_align_monitor_tb_top.sv
module cg_align_monitor_tb_top;
    localparam int IDLE_RUN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_ok = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [4:0] sym_out;
    logic       sym_vld, locked, code_err;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    int vld_seen = 0;
    int err_seen = 0;

    always #5 clk = ~clk;

    cg_align_monitor #(.IDLE_RUN(IDLE_RUN)) dut_i (
        .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .bit_vld(bit_vld),
        .bit_in(bit_in), .sym_out(sym_out), .sym_vld(sym_vld),
        .locked(locked), .code_err(code_err)
    );

    // Behavioural reference model
    int m_st = 0;        // 0 hunting, 1 in stream, 2 after end code
    int m_win = 0;
    int m_cnt = 0;
    int m_idl = 0;
    int e_sym = 0;
    bit e_vld = 0, e_err = 0;
    int legal_q[$] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29,
                       31, 24, 17, 13, 7, 4};

    function automatic bit legal(int c);
        foreach (legal_q[i]) if (legal_q[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        int s;
        e_vld = 0;
        e_err = 0;
        if (!rst_n || !sig_ok) begin
            m_st = 0; m_win = 0; m_cnt = 0; m_idl = 0;
        end else if (bit_vld) begin
            m_win = ((m_win << 1) | int'(bit_in)) & 10'h3FF;
            if (m_st == 0) begin
                if (m_win == 10'b1100010001) begin m_st = 1; m_cnt = 0; m_idl = 0; end
            end else begin
                m_cnt++;
                if (m_cnt == 5) begin
                    m_cnt = 0;
                    s = m_win & 31;
                    e_sym = s; e_vld = 1; e_err = !legal(s);
                    if (m_st == 1) begin
                        if (s == 13 || s == 7) begin m_st = 2; m_idl = 0; end
                    end else begin
                        if (s == 31) begin
                            m_idl++;
                            if (m_idl == IDLE_RUN) begin m_st = 0; m_idl = 0; end
                        end else if (s == 13 || s == 7) m_idl = 0;
                        else begin m_st = 1; m_idl = 0; end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        chk(locked == (m_st != 0), {cur_req, " locked"}, locked, m_st != 0);
        chk(sym_vld == e_vld, {cur_req, " sym_vld"}, sym_vld, e_vld);
        chk(code_err == e_err, {cur_req, " code_err"}, code_err, e_err);
        if (e_vld) chk(sym_out == e_sym[4:0], {cur_req, " sym_out"}, sym_out, e_sym);
        if (sym_vld) vld_seen++;
        if (code_err) err_seen++;
    end

    task automatic drive(input logic v, input logic b);
        bit_vld = v;
        bit_in = b;
        @(posedge clk);
        #3;
    endtask

    task automatic send_sym(input logic [4:0] c, input bit gaps);
        for (int i = 4; i >= 0; i--) begin
            drive(1'b1, c[i]);
            if (gaps && (i % 2 == 0)) drive(1'b0, 1'b1);
        end
        bit_vld = 1'b0;
    endtask

    task automatic lock_up;
        drive(1'b1, 1'b0);
        send_sym(5'b11000, 1'b0);
        send_sym(5'b10001, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk(locked == 0 && sym_vld == 0 && code_err == 0, "R1 reset outputs", locked, 0);
        rst_n = 1'b1;
        @(posedge clk); #3;
        chk(locked == 0, "R1 after release", locked, 0);

        // R3: garbage while hunting, including half a delimiter
        cur_req = "R3";
        vld_seen = 0;
        send_sym(5'b00000, 1'b0); send_sym(5'b11000, 1'b0);
        send_sym(5'b10101, 1'b0); send_sym(5'b10001, 1'b0);
        chk(vld_seen == 0 && locked == 0, "R3 no output while hunting", vld_seen, 0);

        // R2: delimiter after odd leading bits
        cur_req = "R2";
        drive(1'b1, 1'b1); drive(1'b1, 1'b0);
        send_sym(5'b11000, 1'b0);
        send_sym(5'b10001, 1'b0);
        chk(locked == 1, "R2 locked after K", locked, 1);

        // R4, R6, R5: sweep all codes with idle gaps
        cur_req = "R6";
        vld_seen = 0; err_seen = 0;
        for (int c = 0; c < 32; c++) send_sym(5'(c), c[0]);
        @(negedge clk); #1;
        chk(vld_seen == 32, "R4 one strobe per group", vld_seen, 32);
        chk(err_seen == 10, "R6 illegal code count", err_seen, 10);

        cur_req = "R5";
        drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b1, 1'b1); drive(1'b1, 1'b1);
        repeat (7) drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        chk(sym_vld == 1 && sym_out == 5'b10110, "R5 stall keeps position", sym_out, 5'b10110);

        // R7: straddling delimiter while locked
        cur_req = "R7";
        drive(1'b1, 1'b0); drive(1'b1, 1'b1);
        send_sym(5'b11000, 1'b0); send_sym(5'b10001, 1'b0);
        drive(1'b1, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b0);
        bit_vld = 1'b0;
        chk(sym_out == 5'b01000 && code_err == 1, "R7 boundary kept", sym_out, 5'b01000);
        chk(locked == 1, "R7 still locked", locked, 1);

        // R9: interrupted idle run keeps lock
        cur_req = "R9";
        send_sym(5'b00111, 1'b0);
        send_sym(5'b11111, 1'b0); send_sym(5'b11111, 1'b0); send_sym(5'b11111, 1'b0);
        send_sym(5'b01101, 1'b0);
        send_sym(5'b11111, 1'b0); send_sym(5'b11111, 1'b0); send_sym(5'b11111, 1'b0);
        chk(locked == 1, "R9 run restarted by end code", locked, 1);
        send_sym(5'b10100, 1'b0);
        for (int k = 0; k < IDLE_RUN; k++) send_sym(5'b11111, 1'b0);
        chk(locked == 1, "R9 idles in stream do not release", locked, 1);

        // R8: end code then full idle run releases
        cur_req = "R8";
        send_sym(5'b01101, 1'b0);
        for (int k = 0; k < IDLE_RUN - 1; k++) send_sym(5'b11111, 1'b0);
        chk(locked == 1, "R8 one idle short", locked, 1);
        send_sym(5'b11111, 1'b0);
        chk(locked == 0, "R8 released", locked, 0);
        chk(sym_vld == 1 && sym_out == 5'b11111, "R8 last idle delivered", sym_out, 5'b11111);

        // R10: loss of signal
        cur_req = "R10";
        lock_up();
        chk(locked == 1, "R10 relocked", locked, 1);
        drive(1'b1, 1'b1); drive(1'b1, 1'b0);
        sig_ok = 1'b0;
        drive(1'b0, 1'b0);
        sig_ok = 1'b1;
        chk(locked == 0, "R10 dropped", locked, 0);
        vld_seen = 0;
        send_sym(5'b10101, 1'b0); send_sym(5'b01110, 1'b0);
        chk(vld_seen == 0 && locked == 0, "R10 needs new delimiter", vld_seen, 0);
        lock_up();
        chk(locked == 1, "R10 delimiter relocks", locked, 1);

        cur_req = "R11";
        send_sym(5'b11001, 1'b0);
        chk(code_err == 1 && sym_vld == 1, "R11 error with strobe", code_err, 1);
        drive(1'b0, 1'b0);
        chk(code_err == 0, "R11 single pulse", code_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule